// File: doc/BRIEF.md
# Framed Word Serializer with Embedded Boundary Marker

This block turns a strobed parallel word into a source-synchronous serial stream: one data line and a forwarded bit clock that leave the block edge-aligned. Each word travels in a fixed frame of 26 bit positions. The first 24 positions carry data and padding. The last 2 positions form a boundary marker: the clock stays high while the data line goes 1 and then 0. A receiver can lock onto word edges by looking for a data change with a static clock, because that pattern appears nowhere else in the stream.

Bit timing comes from a single-cycle bit enable `bit_ce`, which the surrounding logic derives from the system clock at 13 times the reference rate. When `half_rate` is set, every position lasts two enables. The strobe is asynchronous. It is synchronized inside the block, and its rising edge captures the word into a one-deep holding register. The next frame that starts takes the word from that register. If no word is waiting when a frame starts, that frame sends only zero data and no marker.

Top module: `framed_serializer`

## Requirements
- R1: At full rate, a frame is 26 positions long: 24 data positions followed by 2 boundary positions. Each position lasts exactly one `bit_ce` pulse.
- R2: On a rising edge of the synchronized strobe, `{par_ded, par_shared}` is captured. Input changes made after the capture do not alter the word that is sent.
- R3: The first position sent carries `par_shared[0]`, and positions 1 to 20 carry `par_shared[0..19]` in that order. Positions 21 and 22 carry `par_ded[0]` and `par_ded[1]`. Positions 23 and 24 are always 0.
- R4: In data position k (1-based), `ser_clk` is 0 when k is odd and 1 when k is even. In a data frame, both boundary positions hold `ser_clk` at 1, with `ser_data` at 1 and then 0. A change of `ser_data` while `ser_clk` is unchanged occurs only in the boundary positions.
- R5: A frame that starts with no captured word waiting sends 0 on `ser_data` in all 26 positions. Its clock keeps alternating through the boundary positions (0 then 1), so no marker appears.
- R6: A captured word waits in the holding register until the next frame start. Each captured word is sent in exactly one frame, and words are sent in strobe order.
- R7: When `half_rate` is 1, each position lasts two `bit_ce` pulses, so the serial rate is halved.
- R8: The synchronous reset `rst` sets both serial outputs to 0 and discards any waiting word. The first bit step after reset starts a new frame.
- R9: The serial outputs change only on the clock edge of a bit step, and `ser_clk` and `ser_data` change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_ce | input | 1 | Bit-rate enable, one cycle per bit step |
| half_rate | input | 1 | 1 selects half serial rate |
| strobe | input | 1 | Asynchronous word strobe, rising edge captures |
| par_shared | input | 20 | Shared parallel data bits |
| par_ded | input | 2 | Dedicated parallel data bits |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Forwarded bit clock |

## Verification
The bench builds the block with its default widths (20 shared bits, 2 dedicated bits, 2 pad bits), so every frame has 26 positions. It drives `bit_ce` once every 4 clocks. At full rate, a strobe arriving once per frame makes a capture land close to a frame start and keeps back-to-back words in flight. Slower strobes leave idle frames between words, and the half-rate mode doubles every position. The tests also place a reset between a capture and the next frame start, which checks that the waiting word is discarded.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {RATE_FULL = 1'b0, RATE_HALF = 1'b1} rate_e;
  localparam int unsigned MARK_W = 2;
endpackage

// File: rtl/sfr_strobe_sync.sv
module sfr_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sfr_bit_timer.sv
module sfr_bit_timer
  import sfr_pkg::*;
#(
  parameter int unsigned FRAME = 26,
  parameter int unsigned POS_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_ce,
  input  logic             half_rate,
  output logic             adv,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] nxt_pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME - 1);
  logic  phase_q;
  rate_e rate;

  assign rate    = rate_e'(half_rate);
  assign adv     = bit_ce && (rate == RATE_FULL || phase_q);
  assign nxt_pos = (pos_q == LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= LAST;
      phase_q <= 1'b0;
    end else begin
      if (bit_ce) phase_q <= ~phase_q;
      if (adv)    pos_q   <= nxt_pos;
    end
  end
endmodule

// File: rtl/sfr_frame_shift.sv
module sfr_frame_shift #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [POS_W-1:0]  nxt_pos,
  input  logic              cap_stb,
  input  logic [DATA_W-1:0] cap_word,
  output logic              pend_v,
  output logic              act_q,
  output logic              ser_data,
  output logic              ser_clk
);
  localparam logic [POS_W-1:0] MARK0 = POS_W'(DATA_W);
  logic [DATA_W-1:0] pend_w;
  logic [DATA_W-1:0] shreg;
  logic              frame_start;

  assign frame_start = adv && (nxt_pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_w <= '0;
    end else if (cap_stb) begin
      pend_v <= 1'b1;
      pend_w <= cap_word;
    end else if (frame_start) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      shreg    <= '0;
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
    end else if (adv) begin
      if (frame_start) begin
        act_q    <= pend_v;
        shreg    <= pend_v ? (pend_w >> 1) : '0;
        ser_data <= pend_v & pend_w[0];
        ser_clk  <= 1'b0;
      end else if (nxt_pos < MARK0) begin
        shreg    <= shreg >> 1;
        ser_data <= shreg[0];
        ser_clk  <= nxt_pos[0];
      end else begin
        ser_data <= act_q && (nxt_pos == MARK0);
        ser_clk  <= act_q | nxt_pos[0];
      end
    end
  end
endmodule

// File: rtl/framed_serializer.sv
module framed_serializer
  import sfr_pkg::*;
#(
  parameter int unsigned SHARED_W = 20,
  parameter int unsigned DED_W    = 2,
  parameter int unsigned PAD_W    = 2,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_ce,
  input  logic                half_rate,
  input  logic                strobe,
  input  logic [SHARED_W-1:0] par_shared,
  input  logic [DED_W-1:0]    par_ded,
  output logic                ser_data,
  output logic                ser_clk
);
  localparam int unsigned DATA_W = SHARED_W + DED_W + PAD_W;
  localparam int unsigned FRAME  = DATA_W + MARK_W;
  localparam int unsigned POS_W  = $clog2(FRAME);

  logic              cap_stb;
  logic              adv;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  nxt_pos;
  logic              pend_v;
  logic              act_q;
  logic [DATA_W-1:0] cap_word;

  assign cap_word = {{PAD_W{1'b0}}, par_ded, par_shared};

  sfr_strobe_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .strobe(strobe), .rise(cap_stb)
  );

  sfr_bit_timer #(.FRAME(FRAME), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst(rst), .bit_ce(bit_ce), .half_rate(half_rate),
    .adv(adv), .pos_q(pos_q), .nxt_pos(nxt_pos)
  );

  sfr_frame_shift #(.DATA_W(DATA_W), .POS_W(POS_W)) u_shift (
    .clk(clk), .rst(rst), .adv(adv), .nxt_pos(nxt_pos),
    .cap_stb(cap_stb), .cap_word(cap_word), .pend_v(pend_v),
    .act_q(act_q), .ser_data(ser_data), .ser_clk(ser_clk)
  );
endmodule

// File: rtl/framed_serializer_chk.sv
module framed_serializer_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned PAD_LO = 22,
  parameter int unsigned POS_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic [POS_W-1:0] pos_q,
  input logic             cap_stb,
  input logic             pend_v,
  input logic             act_q,
  input logic             ser_data,
  input logic             ser_clk
);
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!ser_clk && !ser_data));

  p_step_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(ser_clk) && $stable(ser_data)));

  p_marker_place_r4: assert property (@(posedge clk) disable iff (rst)
    ($stable(ser_clk) && !$stable(ser_data)) |-> (pos_q >= POS_W'(DATA_W)));

  p_data_clock_r4: assert property (@(posedge clk) disable iff (rst)
    (pos_q < POS_W'(DATA_W)) |-> (ser_clk == pos_q[0]));

  p_marker_clock_high_r4: assert property (@(posedge clk) disable iff (rst)
    (act_q && pos_q >= POS_W'(DATA_W)) |-> ser_clk);

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (pos_q >= POS_W'(PAD_LO) && pos_q < POS_W'(DATA_W)) |-> !ser_data);

  p_capture_held_r6: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> pend_v);
endmodule

bind framed_serializer framed_serializer_chk #(
  .DATA_W(DATA_W), .PAD_LO(SHARED_W + DED_W), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .pos_q(pos_q), .cap_stb(cap_stb),
  .pend_v(pend_v), .act_q(act_q), .ser_data(ser_data), .ser_clk(ser_clk)
);

// File: tb/framed_serializer_bench.sv
module framed_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CE_DIV     = 4;
  localparam int FRAME      = 26;
  localparam int FRAME_CLK  = FRAME * CE_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_ce = 1'b0;
  logic        half_rate = 1'b0;
  logic        strobe = 1'b0;
  logic [19:0] par_shared = '0;
  logic [1:0]  par_ded = '0;
  logic        ser_data, ser_clk;

  int checks = 0;
  int errors = 0;
  logic [21:0] exp_q[$];

  framed_serializer u_framed_serializer (
    .clk(clk), .rst(rst), .bit_ce(bit_ce), .half_rate(half_rate),
    .strobe(strobe), .par_shared(par_shared), .par_ded(par_ded),
    .ser_data(ser_data), .ser_clk(ser_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ce_cnt = 0;
  always @(negedge clk) begin
    ce_cnt = (ce_cnt == CE_DIV-1) ? 0 : ce_cnt + 1;
    bit_ce <= (ce_cnt == 0);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every position produces a change of the (clk,data) pair
  logic [FRAME-1:0] hc, hd;
  logic [1:0] prev;
  int since, ones_since, frames_seen;
  bit first;
  always @(negedge clk) begin
    if (rst) begin
      hc = '0; hd = '0; prev = 2'b00; since = 0; ones_since = 0; first = 1'b1;
    end else begin
      since++;
      if ({ser_clk, ser_data} != prev) begin
        if (!first)
          check(since == CE_DIV * (half_rate ? 2 : 1), half_rate ? "R7 step" : "R1 step",
                since, CE_DIV * (half_rate ? 2 : 1));
        first = 1'b0;
        since = 0;
        prev = {ser_clk, ser_data};
        hc = {hc[FRAME-2:0], ser_clk};
        hd = {hd[FRAME-2:0], ser_data};
        if (ser_data) ones_since++;
        if (hc[0] && hc[1] && hd[1] && !hd[0]) begin
          logic [23:0] got, want;
          frames_seen++;
          for (int i = 0; i < 24; i++) got[i] = hd[FRAME-1-i];
          for (int i = 0; i < 24; i++)
            check(hc[FRAME-1-i] == i[0], "R4 clock", hc[FRAME-1-i], i[0]);
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected frame", got, 0);
          end else begin
            want = {2'b00, exp_q.pop_front()};
            check(got == want, "R3 word", got, want);
            check(ones_since == $countones(want) + 1, "R5 idle zero", ones_since,
                  $countones(want) + 1);
          end
          ones_since = 0;
        end
      end
    end
  end

  task automatic send_word(input logic [19:0] sh, input logic [1:0] dd, input int period);
    exp_q.push_back({dd, sh});
    par_shared = sh; par_ded = dd;
    @(negedge clk); strobe = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    repeat (10) @(negedge clk);
    par_shared = ~sh; par_ded = ~dd;   // R2: late changes must not leak
    repeat (period - 14) @(negedge clk);
  endtask

  task automatic do_reset(input logic hr);
    @(negedge clk); rst = 1'b1; half_rate = hr;
    repeat (4) @(negedge clk);
    check(ser_clk == 1'b0 && ser_data == 1'b0, "R8 reset outputs", {ser_clk, ser_data}, 0);
    rst = 1'b0;
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          check(1'b0, "watchdog", 0, 1);
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    frames_seen = 0;
    do_reset(1'b0);
    repeat (40) @(negedge clk);
    // R1 R6: back-to-back words at strobe rate equal to frame rate
    send_word(20'hFFFFF, 2'b11, FRAME_CLK);
    send_word(20'h55555, 2'b10, FRAME_CLK);
    send_word(20'h00001, 2'b01, FRAME_CLK);
    send_word(20'h80000, 2'b00, FRAME_CLK);
    send_word(20'h00000, 2'b00, FRAME_CLK);
    // R5: slower strobe leaves idle frames
    send_word(20'hA5C3E, 2'b01, 3 * FRAME_CLK);
    send_word(20'h1248F, 2'b10, 3 * FRAME_CLK);
    repeat (3 * FRAME_CLK) @(negedge clk);
    check(exp_q.size() == 0, "R6 all sent", exp_q.size(), 0);
    check(ones_since == 0, "R5 idle tail", ones_since, 0);
    check(frames_seen == 7, "R6 frame count", frames_seen, 7);

    // R8: reset discards a waiting word
    do_reset(1'b0);
    repeat (8) @(negedge clk);
    par_shared = 20'hFFFFF; par_ded = 2'b11;
    strobe = 1'b1; repeat (3) @(negedge clk); strobe = 1'b0;
    repeat (3) @(negedge clk);
    do_reset(1'b0);
    repeat (3 * FRAME_CLK) @(negedge clk);
    check(frames_seen == 7, "R8 pending cleared", frames_seen, 7);
    check(ones_since == 0, "R8 no data after reset", ones_since, 0);

    // R7: half rate
    do_reset(1'b1);
    repeat (40) @(negedge clk);
    send_word(20'h3C3C3, 2'b11, 2 * FRAME_CLK + 12);
    send_word(20'hF0F0F, 2'b01, 2 * FRAME_CLK + 12);
    send_word(20'h00100, 2'b10, 5 * FRAME_CLK);
    check(exp_q.size() == 0, "R7 all sent", exp_q.size(), 0);
    check(frames_seen == 10, "R7 frame count", frames_seen, 10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule